// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 64-bit linear address into a physical address of up to 52 bits. It walks a radix page table with four levels that lives in memory. A request arrives through a valid/ready handshake. The walker first checks that the address is canonical. It then fetches one 64-bit entry per level through a memory read port whose response can take any number of cycles. A walk ends in a single-cycle completion pulse, which carries either the physical address or a fault code.

Each level uses a 9-bit slice of the linear address to select one 8-byte entry in the current table. Bits 51:12 of that entry give the base of the next table. At the last level they give the frame number instead. Only 4 KB pages are supported. The only entry bit that is judged is the present bit.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and after it is released, `req_ready_o` is 1, and `done_o`, `fault_o` and `mem_req_valid_o` are 0.
- R2: If bits 63:47 of the address are not all equal, the walk ends with `fault_o`=1 and `fault_code_o`=2, and no memory request is issued.
- R3: A canonical walk reads level 0, then 1, then 2, then 3.
  - Level L reads address {base, 12'b0} + 8*idx_L.
  - idx_0 is bits 47:39, idx_1 is bits 38:30, idx_2 is bits 29:21 and idx_3 is bits 20:12.
  - The base is root bits 51:12 for level 0, and bits 51:12 of the previous entry after that.
- R4: Entry bits 63:52 and 11:1, and root bits outside 51:12, have no effect on any address the walker produces.
- R5: If bit 0 of the entry read at level L is 0, the walk ends with `fault_o`=1, `fault_code_o`=1 and `fault_level_o`=L, and no further read is issued.
- R6: A walk in which all four entries are present ends with `fault_o`=0, `fault_code_o`=0 and `paddr_o` = {level-3 entry bits 51:12, address bits 11:0}.
- R7: Each accepted request produces exactly one `done_o` pulse, one cycle long.
- R8: `req_ready_o` is 0 from acceptance until `done_o`. A request offered in that time is not taken and does not change the running walk.
- R9: The walker holds a memory request, with a stable address, until `mem_req_ready_i`. It then accepts a response after any number of cycles.
- R10: In the cycle after `done_o`, `req_ready_o` is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| root_base_i | input | 64 | Root table register; bits 51:12 hold the top table base |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle, request accepted when valid |
| req_vaddr_i | input | 64 | Linear address to translate |
| mem_req_valid_o | output | 1 | Entry read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the read request |
| mem_req_addr_o | output | 52 | Physical byte address of the entry |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 64 | Entry returned by memory |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Walk ended in a fault (valid with done_o) |
| fault_code_o | output | 2 | 0 none, 1 not present, 2 non-canonical |
| fault_level_o | output | 2 | Level whose entry was not present |
| paddr_o | output | 52 | Translated physical address (valid with done_o) |

## Verification
The bench uses the default parameters: 48 used address bits, a 52-bit physical space, 9-bit indices and four levels. With a 52-bit physical space, the entries and the root carry set bits both above bit 51 and below bit 12, so any leak of those bits into an address shows up. The responder changes its request stall and its response latency from vector to vector. It places a missing entry at each of the four levels in turn. The address vectors reach every index at all-ones and at zero, and they cover both sign halves as well as the three kinds of non-canonical pattern.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        WS_IDLE  = 3'd0,
        WS_CHECK = 3'd1,
        WS_READ  = 3'd2,
        WS_DONE  = 3'd3,
        WS_FAULT = 3'd4
    } walk_state_e;

    typedef enum logic [1:0] {
        FC_NONE     = 2'd0,
        FC_ABSENT   = 2'd1,
        FC_NONCANON = 2'd2
    } fault_code_e;

endpackage

// File: rtl/pt_canon_chk.sv
module pt_canon_chk #(
    parameter int VADDR_W = 64,
    parameter int VA_USED = 48
) (
    input  logic [VADDR_W-1:0] vaddr_i,
    output logic               canon_o
);
    localparam int TOP_W = VADDR_W - VA_USED + 1;

    logic [TOP_W-1:0] upper;

    assign upper   = vaddr_i[VADDR_W-1:VA_USED-1];
    assign canon_o = (&upper) | ~(|upper);
endmodule

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
    parameter int VA_USED     = 48,
    parameter int OFF_W       = 12,
    parameter int IDX_W       = 9,
    parameter int LEVELS      = 4,
    parameter int PA_W        = 52,
    parameter int ENTRY_BYTES = 8,
    parameter int LVL_W       = 2
) (
    input  logic [VA_USED-1:0]    va_i,
    input  logic [LVL_W-1:0]      level_i,
    input  logic [PA_W-OFF_W-1:0] base_i,
    output logic [PA_W-1:0]       addr_o
);
    localparam int SH = $clog2(ENTRY_BYTES);

    logic [IDX_W-1:0] idx [LEVELS];
    logic [IDX_W-1:0] sel;

    genvar g;
    generate
        for (g = 0; g < LEVELS; g++) begin : g_slice
            assign idx[g] = va_i[VA_USED-1-g*IDX_W -: IDX_W];
        end
    endgenerate

    always_comb begin
        sel = '0;
        for (int l = 0; l < LEVELS; l++) begin
            if (level_i == LVL_W'(l)) sel = idx[l];
        end
    end

    assign addr_o = {base_i, {OFF_W{1'b0}}} + (PA_W'(sel) << SH);
endmodule

// File: rtl/pt_entry_decode.sv
module pt_entry_decode #(
    parameter int ENTRY_W     = 64,
    parameter int PA_W        = 52,
    parameter int OFF_W       = 12,
    parameter int PRESENT_BIT = 0
) (
    input  logic [ENTRY_W-1:0]    entry_i,
    output logic                  present_o,
    output logic [PA_W-OFF_W-1:0] ppn_o
);
    assign present_o = entry_i[PRESENT_BIT];
    assign ppn_o     = entry_i[PA_W-1:OFF_W];
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
    parameter int VADDR_W = 64,
    parameter int VA_USED = 48,
    parameter int PA_W    = 52,
    parameter int OFF_W   = 12,
    parameter int IDX_W   = 9,
    parameter int LEVELS  = 4,
    parameter int ENTRY_W = 64
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [ENTRY_W-1:0]         root_base_i,
    input  logic                       req_valid_i,
    output logic                       req_ready_o,
    input  logic [VADDR_W-1:0]         req_vaddr_i,
    output logic                       mem_req_valid_o,
    input  logic                       mem_req_ready_i,
    output logic [PA_W-1:0]            mem_req_addr_o,
    input  logic                       mem_rsp_valid_i,
    input  logic [ENTRY_W-1:0]         mem_rsp_data_i,
    output logic                       done_o,
    output logic                       fault_o,
    output logic [1:0]                 fault_code_o,
    output logic [$clog2(LEVELS)-1:0]  fault_level_o,
    output logic [PA_W-1:0]            paddr_o
);
    import ptw_pkg::*;

    localparam int PPN_W       = PA_W - OFF_W;
    localparam int LVL_W       = $clog2(LEVELS);
    localparam int ENTRY_BYTES = ENTRY_W / 8;

    typedef struct packed {
        walk_state_e        st;
        logic [VADDR_W-1:0] va;
        logic [PPN_W-1:0]   base;
        logic [LVL_W-1:0]   lvl;
        logic               sent;
        logic [PA_W-1:0]    pa;
        fault_code_e        fc;
    } walk_regs_t;

    walk_regs_t       r_d, r_q;
    logic             canon_ok;
    logic             ent_present;
    logic [PPN_W-1:0] ent_ppn;
    logic [PA_W-1:0]  ent_addr;

    pt_canon_chk #(
        .VADDR_W (VADDR_W),
        .VA_USED (VA_USED)
    ) u_canon (
        .vaddr_i (r_q.va),
        .canon_o (canon_ok)
    );

    pt_entry_addr #(
        .VA_USED     (VA_USED),
        .OFF_W       (OFF_W),
        .IDX_W       (IDX_W),
        .LEVELS      (LEVELS),
        .PA_W        (PA_W),
        .ENTRY_BYTES (ENTRY_BYTES),
        .LVL_W       (LVL_W)
    ) u_addr (
        .va_i    (r_q.va[VA_USED-1:0]),
        .level_i (r_q.lvl),
        .base_i  (r_q.base),
        .addr_o  (ent_addr)
    );

    pt_entry_decode #(
        .ENTRY_W     (ENTRY_W),
        .PA_W        (PA_W),
        .OFF_W       (OFF_W),
        .PRESENT_BIT (0)
    ) u_decode (
        .entry_i   (mem_rsp_data_i),
        .present_o (ent_present),
        .ppn_o     (ent_ppn)
    );

    always_comb begin
        r_d             = r_q;
        req_ready_o     = 1'b0;
        mem_req_valid_o = 1'b0;
        unique case (r_q.st)
            WS_IDLE: begin
                req_ready_o = 1'b1;
                if (req_valid_i) begin
                    r_d.va   = req_vaddr_i;
                    r_d.fc   = FC_NONE;
                    r_d.pa   = '0;
                    r_d.lvl  = '0;
                    r_d.sent = 1'b0;
                    r_d.st   = WS_CHECK;
                end
            end
            WS_CHECK: begin
                if (!canon_ok) begin
                    r_d.fc = FC_NONCANON;
                    r_d.st = WS_FAULT;
                end else begin
                    r_d.base = root_base_i[PA_W-1:OFF_W];
                    r_d.lvl  = '0;
                    r_d.sent = 1'b0;
                    r_d.st   = WS_READ;
                end
            end
            WS_READ: begin
                mem_req_valid_o = !r_q.sent;
                if (!r_q.sent && mem_req_ready_i) begin
                    r_d.sent = 1'b1;
                end
                if (r_q.sent && mem_rsp_valid_i) begin
                    if (!ent_present) begin
                        r_d.fc = FC_ABSENT;
                        r_d.st = WS_FAULT;
                    end else if (r_q.lvl == LVL_W'(LEVELS - 1)) begin
                        r_d.pa = {ent_ppn, r_q.va[OFF_W-1:0]};
                        r_d.st = WS_DONE;
                    end else begin
                        r_d.base = ent_ppn;
                        r_d.lvl  = LVL_W'(r_q.lvl + 1'b1);
                        r_d.sent = 1'b0;
                    end
                end
            end
            WS_DONE:  r_d.st = WS_IDLE;
            WS_FAULT: r_d.st = WS_IDLE;
            default:  r_d.st = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{st: WS_IDLE, va: '0, base: '0, lvl: '0, sent: 1'b0,
                     pa: '0, fc: FC_NONE};
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_req_addr_o = ent_addr;
    assign done_o         = (r_q.st == WS_DONE) || (r_q.st == WS_FAULT);
    assign fault_o        = (r_q.st == WS_FAULT);
    assign fault_code_o   = r_q.fc;
    assign fault_level_o  = r_q.lvl;
    assign paddr_o        = r_q.pa;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R7
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_ready_o) |=> !req_ready_o); // R8
    AST_CHECK_BEFORE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_ready_o) |=> !mem_req_valid_o); // R2
    AST_MEMREQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o))); // R9
    AST_OK_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !fault_o) |-> (fault_code_o == FC_NONE)); // R6
    AST_FAULT_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && fault_o) |-> (fault_code_o != FC_NONE)); // R5
    AST_READY_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> req_ready_o); // R10

endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;

    typedef struct packed {
        logic [63:0] va;
        logic [63:0] root;
        logic [2:0]  np;     // level with absent entry, 4 = none
        logic [1:0]  lat;
        logic [1:0]  stall;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{64'h0000_1234_5678_9ABC, 64'h0000_0000_0010_0000, 3'd4, 2'd0, 2'd0},
        '{64'hFFFF_8000_0000_0FFF, 64'hFFF0_0ABC_DEF0_1FFF, 3'd4, 2'd3, 2'd2},
        '{64'h0000_7FFF_FFFF_FFFF, 64'h000F_FFFF_FFFF_F000, 3'd4, 2'd1, 2'd1},
        '{64'h0000_0040_2010_0123, 64'h0000_0000_0020_0000, 3'd0, 2'd2, 2'd0},
        '{64'hFFFF_FFFF_FFFF_F000, 64'h0000_0000_0030_0000, 3'd1, 2'd0, 2'd3},
        '{64'h0000_0000_0000_0000, 64'h0000_0000_0040_0000, 3'd2, 2'd1, 2'd1},
        '{64'h0000_5555_AAAA_5555, 64'h0000_0000_0050_0000, 3'd3, 2'd3, 2'd0},
        '{64'h0000_8000_0000_0000, 64'h0000_0000_0060_0000, 3'd4, 2'd0, 2'd0},
        '{64'hFFFF_7FFF_FFFF_FFFF, 64'h0000_0000_0070_0000, 3'd4, 2'd0, 2'd0},
        '{64'h0001_0000_0000_0000, 64'h0000_0000_0080_0000, 3'd4, 2'd0, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] root_base;
    logic        req_valid;
    logic        req_ready;
    logic [63:0] req_vaddr;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [51:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;
    logic        done;
    logic        fault;
    logic [1:0]  fault_code;
    logic [1:0]  fault_level;
    logic [51:0] paddr;

    always #5 clk = ~clk;

    pt_walker u_dut (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .root_base_i     (root_base),
        .req_valid_i     (req_valid),
        .req_ready_o     (req_ready),
        .req_vaddr_i     (req_vaddr),
        .mem_req_valid_o (mem_req_valid),
        .mem_req_ready_i (mem_req_ready),
        .mem_req_addr_o  (mem_req_addr),
        .mem_rsp_valid_i (mem_rsp_valid),
        .mem_rsp_data_i  (mem_rsp_data),
        .done_o          (done),
        .fault_o         (fault),
        .fault_code_o    (fault_code),
        .fault_level_o   (fault_level),
        .paddr_o         (paddr)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [39:0] frame(input int vi, input int l);
        return 40'hC_0000_0000 + (40'(vi) << 12) + (40'(l) << 4) + 40'h5;
    endfunction

    // responder state
    int          cur_vi = 0;
    int          walk_lvl = 0;
    int          n_reqs = 0;
    int          stall_left = 0;
    bit          pend = 1'b0;
    int          cnt = 0;
    logic [63:0] pdata = '0;

    always @(negedge clk) begin
        logic [39:0] base;
        logic [8:0]  idx;
        logic [51:0] exp_a;
        mem_rsp_valid = 1'b0;
        if (pend) begin
            if (cnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = pdata;
                pend          = 1'b0;
            end else begin
                cnt--;
            end
        end
        mem_req_ready = 1'b0;
        if (rst_n && mem_req_valid && !pend && !mem_rsp_valid) begin
            if (stall_left > 0) begin
                stall_left--;
            end else begin
                mem_req_ready = 1'b1;
                base  = (walk_lvl == 0) ? VEC[cur_vi].root[51:12] : frame(cur_vi, walk_lvl - 1);
                idx   = VEC[cur_vi].va[47 - 9*walk_lvl -: 9];
                exp_a = {base, 12'h000} + 52'(idx) * 52'd8;
                chk(mem_req_addr == exp_a, $sformatf("R3 R4 entry address level %0d", walk_lvl),
                    64'(mem_req_addr), 64'(exp_a));
                if (walk_lvl == int'(VEC[cur_vi].np))
                    pdata = {12'hFFF, frame(cur_vi, walk_lvl), 11'h7FF, 1'b0};
                else
                    pdata = {12'hA5C, frame(cur_vi, walk_lvl), 11'h2AA, 1'b1};
                pend       = 1'b1;
                cnt        = int'(VEC[cur_vi].lat);
                stall_left = int'(VEC[cur_vi].stall);
                walk_lvl++;
                n_reqs++;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n        = 1'b0;
        root_base    = '0;
        req_valid    = 1'b0;
        req_vaddr    = '0;
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready in reset", 64'(req_ready), 64'd1);
        chk(done == 1'b0 && fault == 1'b0, "R1 done/fault in reset", 64'({done, fault}), 64'd0);
        chk(mem_req_valid == 1'b0, "R1 mem valid in reset", 64'(mem_req_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1 && done == 1'b0 && mem_req_valid == 1'b0, "R1 idle after reset",
            64'({req_ready, done, mem_req_valid}), 64'h4);

        for (int i = 0; i < NV; i++) begin
            logic [63:0] va;
            bit          canon;
            int          waited;
            int          rdy_err;
            int          exp_reqs;
            va         = VEC[i].va;
            canon      = (&va[63:47]) || !(|va[63:47]);
            cur_vi     = i;
            walk_lvl   = 0;
            n_reqs     = 0;
            stall_left = int'(VEC[i].stall);
            root_base  = VEC[i].root;
            req_valid  = 1'b1;
            req_vaddr  = va;
            @(negedge clk);
            // busy: offer a different request that must be ignored
            req_vaddr = 64'h0000_0123_4567_8000;
            waited    = 0;
            rdy_err   = 0;
            while (!done && waited < 300) begin
                if (req_ready) rdy_err++;
                @(negedge clk);
                waited++;
            end
            req_valid = 1'b0;
            if (!done) begin
                chk(1'b0, $sformatf("R7 walk %0d timed out", i), 64'd0, 64'd1);
                continue;
            end
            chk(rdy_err == 0, $sformatf("R8 ready while busy, vec %0d", i), 64'(rdy_err), 64'd0);
            exp_reqs = !canon ? 0 : (VEC[i].np < 4) ? int'(VEC[i].np) + 1 : 4;
            chk(n_reqs == exp_reqs, $sformatf("R3 R5 R2 read count, vec %0d", i),
                64'(n_reqs), 64'(exp_reqs));
            if (!canon) begin
                chk(fault == 1'b1 && fault_code == 2'd2, $sformatf("R2 non-canonical, vec %0d", i),
                    64'({fault, fault_code}), 64'h6);
            end else if (VEC[i].np < 4) begin
                chk(fault == 1'b1 && fault_code == 2'd1, $sformatf("R5 absent code, vec %0d", i),
                    64'({fault, fault_code}), 64'h5);
                chk(fault_level == VEC[i].np[1:0], $sformatf("R5 absent level, vec %0d", i),
                    64'(fault_level), 64'(VEC[i].np[1:0]));
            end else begin
                chk(fault == 1'b0 && fault_code == 2'd0, $sformatf("R6 success code, vec %0d", i),
                    64'({fault, fault_code}), 64'h0);
                chk(paddr == {frame(i, 3), va[11:0]}, $sformatf("R6 R4 R8 paddr, vec %0d", i),
                    64'(paddr), 64'({frame(i, 3), va[11:0]}));
            end
            @(negedge clk);
            chk(done == 1'b0, $sformatf("R7 single done pulse, vec %0d", i), 64'(done), 64'd0);
            chk(req_ready == 1'b1, $sformatf("R10 ready after done, vec %0d", i), 64'(req_ready), 64'd1);
        end

        // directed: R9 stall behaviour observed over the longest stall vector is covered above;
        // final idle check
        @(negedge clk);
        chk(mem_req_valid == 1'b0 && done == 1'b0, "R1 R10 quiet at end",
            64'({mem_req_valid, done}), 64'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule